// File: doc/BRIEF.md
# Count-Based Response Compactor

This block sits behind a circuit under test and turns that circuit's serial single-bit response into a short count signature. A session starts with a one-cycle start strobe. The block then accepts a fixed number of response bits, set by the parameter `SESSION_LEN` (L). A bit is accepted only in a cycle where its valid flag is high. At the end of the session the count is compared against a golden value supplied by the surrounding test logic. A done flag and a pass flag report the result, and both stay in place until the next start.

Two counting rules are available. One rule counts the ones in the stream. The other counts changes between consecutive accepted bits: each 0-to-1 and each 1-to-0 step adds one. For the change rule, a register keeps the previously accepted bit. The counter advances when the XOR of that stored bit and the new bit is high. The rule is chosen with the mode input and captured when the session starts.

Top module: `resp_count_compactor`

## Requirements
- R1: After reset, `sig_o` is 0, `done_o` and `pass_o` are low, and no session is open.
- R2: With mode code 0 captured at start, the signature grows by one for each accepted bit equal to 1. For the stream 0101100 it ends at 3.
- R3: With mode code 1 captured at start, the signature grows by one for each accepted bit that differs from the previous accepted bit. For the stream 0101100 it ends at 4.
- R4: In mode code 1, the first accepted bit of a session never counts as a change. No earlier bit of that session is held, whatever value reset or an earlier session left behind.
- R5: A cycle with `resp_valid_i` low changes neither the signature nor the stored previous bit.
- R6: `done_o` rises in the clock cycle after the L-th accepted bit. It is low before that, and it stays high until the next start. Bits offered while it is high are ignored.
- R7: `pass_o` rises together with `done_o` exactly when the final signature equals `golden_i` at the edge that accepts the L-th bit. Otherwise it stays low.
- R8: A start clears the signature, the stored previous bit, `done_o` and `pass_o`, and opens a new session. A response bit offered in the same cycle as the start is not accepted.
- R9: The signature is ceil(log2(L+1)) bits wide and saturates at its all-ones value instead of wrapping. An all-ones stream in mode code 0 ends at exactly L.
- R10: The mode is sampled only at start. Changing `mode_i` during a session has no effect on that session.
- R11: Before the first start after reset, valid bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle strobe that opens a new session |
| resp_valid_i | input | 1 | Response bit valid in this cycle |
| resp_bit_i | input | 1 | Serial response bit from the circuit under test |
| mode_i | input | 1 | Counting rule: 0 counts ones, 1 counts changes |
| golden_i | input | CNT_W | Fault-free signature to compare against |
| sig_o | output | CNT_W | Current count signature |
| done_o | output | 1 | Session of L accepted bits complete |
| pass_o | output | 1 | Final signature matched the golden value |

## Verification
The same streams are run under both counting rules, so a mix-up between the two rules shows as a wrong count. The mixed stream 0101100 separates a ones count of 3 from a change count of 4. An all-ones stream gives full scale under the ones rule and zero under the change rule. Two further streams, a lone leading 1 followed by zeros and an alternating stream, show whether the first bit is wrongly counted as a change and whether the count reaches its maximum of L-1. Each stream is replayed with idle cycles between bits that carry opposite garbage. A deliberately wrong golden value checks that the pass flag drops while the signature stays correct.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic {
    MODE_ONES  = 1'b0,
    MODE_EDGES = 1'b1
  } rcc_mode_e;

  // Count event for one accepted bit under the given rule.
  function automatic logic count_event(rcc_mode_e mode, logic cur_bit,
                                       logic prev_bit, logic prev_valid);
    if (mode == MODE_ONES) return cur_bit;
    return prev_valid & (cur_bit ^ prev_bit);
  endfunction

endpackage

// File: rtl/rcc_session_ctrl.sv
module rcc_session_ctrl
  import rcc_pkg::*;
#(
  parameter int SESSION_LEN = 64,
  parameter int CNT_W       = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      resp_valid_i,
  input  logic      mode_i,
  output rcc_mode_e mode_q,
  output logic      take_o,
  output logic      last_o,
  output logic      done_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SESSION_LEN - 1);

  logic             active_q;
  logic [CNT_W-1:0] seen_q;

  assign take_o = active_q & resp_valid_i & ~start_i;
  assign last_o = take_o & (seen_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_o   <= 1'b0;
      seen_q   <= '0;
      mode_q   <= MODE_ONES;
    end else if (start_i) begin
      active_q <= 1'b1;
      done_o   <= 1'b0;
      seen_q   <= '0;
      mode_q   <= rcc_mode_e'(mode_i);
    end else if (take_o) begin
      if (last_o) begin
        active_q <= 1'b0;
        done_o   <= 1'b1;
        seen_q   <= '0;
      end else begin
        seen_q <= seen_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rcc_event_gen.sv
module rcc_event_gen
  import rcc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear_i,
  input  logic      take_i,
  input  logic      bit_i,
  input  rcc_mode_e mode_i,
  output logic      hit_o
);
  logic prev_bit_q;
  logic prev_valid_q;

  assign hit_o = take_i & count_event(mode_i, bit_i, prev_bit_q, prev_valid_q);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      prev_bit_q   <= 1'b0;
      prev_valid_q <= 1'b0;
    end else if (take_i) begin
      prev_bit_q   <= bit_i;
      prev_valid_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rcc_sat_counter.sv
module rcc_sat_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_step(logic [CNT_W-1:0] v, logic inc);
    if (inc && v != CNT_MAX) return v + 1'b1;
    return v;
  endfunction

  assign cnt_next_o = sat_step(cnt_o, inc_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) cnt_o <= '0;
    else                   cnt_o <= cnt_next_o;
  end
endmodule

// File: rtl/resp_count_compactor.sv
module resp_count_compactor
  import rcc_pkg::*;
#(
  parameter  int SESSION_LEN = 64,
  localparam int CNT_W       = $clog2(SESSION_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             resp_valid_i,
  input  logic             resp_bit_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] golden_i,
  output logic [CNT_W-1:0] sig_o,
  output logic             done_o,
  output logic             pass_o
);
  rcc_mode_e        mode_q;
  logic             take_w;
  logic             last_w;
  logic             hit_w;
  logic [CNT_W-1:0] cnt_next_w;

  rcc_session_ctrl #(.SESSION_LEN(SESSION_LEN), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .resp_valid_i(resp_valid_i),
    .mode_i(mode_i), .mode_q(mode_q), .take_o(take_w), .last_o(last_w),
    .done_o(done_o)
  );

  rcc_event_gen evt_i (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .take_i(take_w),
    .bit_i(resp_bit_i), .mode_i(mode_q), .hit_o(hit_w)
  );

  rcc_sat_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .inc_i(hit_w),
    .cnt_o(sig_o), .cnt_next_o(cnt_next_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || start_i) pass_o <= 1'b0;
    else if (last_w)       pass_o <= (cnt_next_w == golden_i);
  end
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             resp_valid_i,
  input logic [CNT_W-1:0] sig_o,
  input logic             done_o,
  input logic             pass_o,
  input logic             take_w,
  input logic             hit_w,
  input logic             last_w
);
  localparam logic [CNT_W-1:0] SIG_MAX = '1;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (sig_o == $past(sig_o)) || (sig_o == $past(sig_o) + 1'b1));

  assert_event_needs_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w |-> take_w);

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!resp_valid_i && !start_i) |=> $stable(sig_o));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> done_o);

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(sig_o) && $stable(pass_o)));

  assert_pass_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> done_o);

  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (sig_o == '0 && !done_o && !pass_o));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_o == SIG_MAX && !start_i) |=> sig_o == SIG_MAX);
endmodule

bind resp_count_compactor rcc_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .resp_valid_i(resp_valid_i),
  .sig_o(sig_o), .done_o(done_o), .pass_o(pass_o),
  .take_w(take_w), .hit_w(hit_w), .last_w(last_w)
);

// File: tb/resp_count_compactor_tb_top.sv
module resp_count_compactor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 7;
  localparam int CW = $clog2(L + 1);
  localparam int NV = 10;

  // stream sent MSB first; mode 0 = ones, 1 = changes
  localparam logic [L-1:0]  V_BITS [NV] = '{7'b0101100, 7'b0101100, 7'b0101100,
    7'b1111111, 7'b1111111, 7'b1010101, 7'b0000000, 7'b1000000, 7'b0110011, 7'b0110011};
  localparam logic          V_MODE [NV] = '{0, 1, 0, 0, 1, 1, 0, 1, 0, 1};
  localparam logic [CW-1:0] V_GOLD [NV] = '{3, 4, 4, 7, 0, 6, 1, 1, 4, 3};
  localparam logic [CW-1:0] V_SIG  [NV] = '{3, 4, 3, 7, 0, 6, 0, 1, 4, 3};
  localparam logic          V_PASS [NV] = '{1, 1, 0, 1, 1, 1, 0, 1, 1, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, resp_valid_i = 1'b0, resp_bit_i = 1'b0, mode_i = 1'b0;
  logic [CW-1:0] golden_i = '0;
  logic [CW-1:0] sig_o;
  logic done_o, pass_o;
  int total = 0, bad = 0;
  bit ended = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  resp_count_compactor #(.SESSION_LEN(L)) dut_i (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic open_session(logic m, logic [CW-1:0] g);
    @(negedge clk);
    start_i = 1'b1; resp_valid_i = 1'b0; mode_i = m; golden_i = g;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send_bits(logic [L-1:0] bits, bit gaps, bit flip_mode);
    for (int k = L - 1; k >= 0; k--) begin
      if (k == 0) chk("R6 done low before last bit", int'(done_o), 0);
      resp_valid_i = 1'b1; resp_bit_i = bits[k];
      @(negedge clk);
      if (flip_mode) mode_i = ~mode_i;
      if (gaps && k != 0) begin
        resp_valid_i = 1'b0; resp_bit_i = ~bits[k];
        @(negedge clk);
      end
    end
    resp_valid_i = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sig after reset", int'(sig_o), 0);
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 pass after reset", int'(pass_o), 0);
    rst_n = 1'b1;

    // R11: bits before the first start are ignored
    resp_valid_i = 1'b1; resp_bit_i = 1'b1;
    repeat (4) @(negedge clk);
    resp_valid_i = 1'b0;
    chk("R11 sig before start", int'(sig_o), 0);
    chk("R11 done before start", int'(done_o), 0);

    // vector table: R2 R3 R4 R5 R7 R9
    for (int i = 0; i < NV; i++) begin
      open_session(V_MODE[i], V_GOLD[i]);
      send_bits(V_BITS[i], (i % 2) == 1, 1'b0);
      chk(V_MODE[i] ? "R3 change signature" : "R2 ones signature",
          int'(sig_o), int'(V_SIG[i]));
      chk("R6 done after L bits", int'(done_o), 1);
      chk("R7 pass vs golden", int'(pass_o), int'(V_PASS[i]));
    end

    // R6: bits after done ignored (last session: sig 3, pass 1)
    resp_valid_i = 1'b1; resp_bit_i = 1'b1; golden_i = '0;
    repeat (3) begin
      @(negedge clk);
      resp_bit_i = ~resp_bit_i;
    end
    resp_valid_i = 1'b0;
    @(negedge clk);
    chk("R6 sig frozen after done", int'(sig_o), 3);
    chk("R6 done held", int'(done_o), 1);
    chk("R7 pass held", int'(pass_o), 1);

    // R8: start clears; bit offered with start is not accepted
    @(negedge clk);
    start_i = 1'b1; mode_i = 1'b0; golden_i = 3'd0;
    resp_valid_i = 1'b1; resp_bit_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; resp_valid_i = 1'b0;
    chk("R8 sig cleared", int'(sig_o), 0);
    chk("R8 done cleared", int'(done_o), 0);
    chk("R8 pass cleared", int'(pass_o), 0);
    send_bits(7'b0000000, 1'b0, 1'b0);
    chk("R8 start-cycle bit ignored", int'(sig_o), 0);
    chk("R8 session length unchanged", int'(done_o), 1);

    // R10: mode toggled during session has no effect
    open_session(1'b0, 3'd3);
    send_bits(7'b0101100, 1'b0, 1'b1);
    chk("R10 mode held from start", int'(sig_o), 3);
    chk("R10 pass", int'(pass_o), 1);

    // R4: previous session ended on 0; new change session starts with 1
    open_session(1'b1, 3'd0);
    send_bits(7'b1111111, 1'b0, 1'b0);
    chk("R4 first bit not a change", int'(sig_o), 0);

    // R1: reset in mid-session
    open_session(1'b0, 3'd0);
    resp_valid_i = 1'b1; resp_bit_i = 1'b1;
    repeat (3) @(negedge clk);
    resp_valid_i = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 sig after mid reset", int'(sig_o), 0);
    chk("R1 done after mid reset", int'(done_o), 0);

    finish_up();
  end
endmodule